// File: doc/BRIEF.md
# Descriptor-Chained Audio DMA Channel

This block is one audio DMA channel. Software writes the address of a descriptor chain and a control word. The channel then reads each descriptor, which holds a buffer address, a count word and the address of the next descriptor. It moves the buffer's bytes as 16-bit halfwords between memory and its own slice of an on-chip FIFO, and then follows the link to the next descriptor. If the last descriptor links back to the first, the chain forms a ring and the channel runs without end.

The control word picks the direction: transmit moves memory to the device, and receive moves the device to memory. It also places the channel's slice within the FIFO and sets a high-water mark that gates the device-side request. A descriptor can ask for an interrupt when it completes. The status bit for that interrupt can be polled in the control register, and reading the control register clears it. A third register shows the buffer address that is currently being transferred.

Top module: `adma_chan`

## Requirements
- R1: After reset the control register reads 0, the buffer pointer reads 0, and `irq`, `mem_req` and `dev_req` are low.
- R2: A write to register 0 with bit 1 (active) set starts the channel at the descriptor pointer last written to register 1. The channel reads three full words (`mem_hw`=0) at P, P+4 and P+8: the buffer address, the count word and the next-descriptor address.
- R3: In transmit (control bit 3 clear), the channel reads buffer halfwords at ascending addresses, with data on `mem_rdata[15:0]`. It presents them on `dev_rdata` in the same order, and each `dev_pop` advances to the next one.
- R4: In receive (control bit 3 set), halfwords pushed with `dev_push` are written to memory at ascending buffer addresses, with `mem_we`=1, `mem_hw`=1 and data on `mem_wdata[15:0]`.
- R5: The count word holds a byte count in bits 13:0, and bit 0 is ignored. A descriptor makes exactly count/2 halfword accesses. A count of 0 completes right after its fetch, with no data access.
- R6: When a descriptor's count runs out, the channel fetches the descriptor at its next address in the following cycle. A chain that links back to an earlier descriptor repeats without end.
- R7: Bit 31 of the count word requests an interrupt. Completing such a descriptor sets status bit 0 of the control register. Completing a descriptor without it leaves the status unchanged.
- R8: `irq` equals the status bit. A read of register 0 returns the status and clears it. If a completion with an interrupt request falls in the same cycle as that read, the status stays set.
- R9: A write to register 0 with bit 1 clear stops the channel. `mem_req` is low from the next cycle on, and bit 1 then reads 0.
- R10: Control bits 23:16 (begin) and 31:24 (end) place the channel's slice in doublewords. The slice holds (end-begin)*4 halfwords, clamped to the FIFO size. In transmit, memory reads stop while the slice is full.
- R11: Control bits 15:8 set the high-water mark in halfwords, and a value of 0 counts as 1. While running, `dev_req` is high in transmit when the slice level is at least the mark, and in receive when the free space is at least the mark.
- R12: Register 2 reads the address of the next buffer halfword to be transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on register 0) |
| reg_addr | input | 2 | Register select: 0 control, 1 descriptor pointer, 2 buffer pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt status |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write |
| mem_hw | output | 1 | Halfword access (else full word) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data (halfword in 15:0) |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | 32 | Memory read data, valid with grant |
| dev_req | output | 1 | Device service request |
| dev_push | input | 1 | Device pushes a halfword (receive) |
| dev_wdata | input | 16 | Halfword from the device |
| dev_pop | input | 1 | Device takes a halfword (transmit) |
| dev_rdata | output | 16 | Halfword to the device |

## Verification
Two events can fall in the same cycle: a descriptor completion that requests an interrupt, and a software read of the control register that clears the status. The bench uses a zero-count descriptor with the request bit set. It withholds the memory grant until the channel is waiting on the third descriptor word, then releases the grant in the same cycle as a control read. The read must return the status as still clear, and `irq` must be high afterwards. A later read then returns the status set and clears it.

// File: rtl/adma_pkg.sv
package adma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_W0,
    ST_W1,
    ST_W2,
    ST_XFER
  } walk_st_e;

  localparam int IE_BIT   = 31;
  localparam int ACT_BIT  = 1;
  localparam int LOAD_BIT = 2;
  localparam int RCV_BIT  = 3;

  // halfword index where a slice starts, clamped to the FIFO size
  function automatic int slice_lo(input int beg, input int dw);
    return ((beg > dw) ? dw : beg) * 4;
  endfunction

  function automatic int slice_hi(input int fin, input int dw);
    return ((fin > dw) ? dw : fin) * 4;
  endfunction

  function automatic int slice_cap(input int beg, input int fin, input int dw);
    int lo;
    int hi;
    lo = slice_lo(beg, dw);
    hi = slice_hi(fin, dw);
    return (hi > lo) ? (hi - lo) : 0;
  endfunction

  function automatic int mark_eff(input int hwm);
    return (hwm == 0) ? 1 : hwm;
  endfunction

endpackage

// File: rtl/adma_fifo.sv
module adma_fifo
  import adma_pkg::*;
#(
  parameter int DW = 8,
  localparam int DEPTH = DW * 4,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic [7:0]    beg_i,
  input  logic [7:0]    end_i,
  input  logic          push_i,
  input  logic [15:0]   pdata_i,
  input  logic          pop_i,
  output logic [15:0]   head_o,
  output logic [LW-1:0] level_o,
  output logic [LW-1:0] cap_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [15:0]   store [DEPTH];
  logic [LW-1:0] wr_q, rd_q, lvl_q, lo, hi;

  function automatic logic [LW-1:0] step(input logic [LW-1:0] p,
                                         input logic [LW-1:0] lo_v,
                                         input logic [LW-1:0] hi_v);
    return ((p + LW'(1)) >= hi_v) ? lo_v : (p + LW'(1));
  endfunction

  always_comb begin
    lo    = LW'(slice_lo(int'(beg_i), DW));
    hi    = LW'(slice_hi(int'(end_i), DW));
    cap_o = LW'(slice_cap(int'(beg_i), int'(end_i), DW));
  end

  assign level_o = lvl_q;
  assign full_o  = (lvl_q >= cap_o);
  assign empty_o = (lvl_q == '0);
  assign head_o  = store[rd_q[IW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wr_q  <= lo;
      rd_q  <= lo;
      lvl_q <= '0;
    end else begin
      if (push_i) wr_q <= step(wr_q, lo, hi);
      if (pop_i)  rd_q <= step(rd_q, lo, hi);
      lvl_q <= lvl_q + LW'(push_i) - LW'(pop_i);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !flush_i) store[wr_q[IW-1:0]] <= pdata_i;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !flush_i) |-> !full_o); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !flush_i) |-> !empty_o); // R3

endmodule

// File: rtl/adma_walk.sv
module adma_walk
  import adma_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        stop_i,
  input  logic [31:0] dptr_i,
  input  logic        rcv_i,
  input  logic        fifo_full_i,
  input  logic        fifo_empty_i,
  input  logic [15:0] fifo_head_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic        mem_hw_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  input  logic        mem_gnt_i,
  input  logic [31:0] mem_rdata_i,
  output logic        push_o,
  output logic        pop_o,
  output logic [15:0] pdata_o,
  output logic        desc_done_o,
  output logic        desc_irq_o,
  output logic [31:0] dptr_o,
  output logic [31:0] bptr_o
);

  walk_st_e   st_q;
  logic [31:0] dptr_q, bptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic       ie_q;
  logic       beat, xfer_ok, last_beat, zero_desc;

  assign xfer_ok = rcv_i ? !fifo_empty_i : !fifo_full_i;

  always_comb begin
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    mem_hw_o   = 1'b0;
    mem_addr_o = bptr_q;
    unique case (st_q)
      ST_W0:   begin mem_req_o = 1'b1; mem_addr_o = dptr_q; end
      ST_W1:   begin mem_req_o = 1'b1; mem_addr_o = dptr_q + 32'd4; end
      ST_W2:   begin mem_req_o = 1'b1; mem_addr_o = dptr_q + 32'd8; end
      ST_XFER: begin mem_req_o = xfer_ok; mem_hw_o = 1'b1; mem_we_o = rcv_i; end
      default: ;
    endcase
  end

  assign mem_wdata_o = {16'h0000, fifo_head_i};
  assign beat        = mem_req_o && mem_gnt_i;
  assign last_beat   = (st_q == ST_XFER) && beat && (cnt_q == CNT_W'(2));
  assign zero_desc   = (st_q == ST_W2) && beat && (cnt_q == '0);
  assign desc_done_o = last_beat || zero_desc;
  assign desc_irq_o  = desc_done_o && ie_q;
  assign push_o      = (st_q == ST_XFER) && beat && !rcv_i;
  assign pop_o       = (st_q == ST_XFER) && beat && rcv_i;
  assign pdata_o     = mem_rdata_i[15:0];
  assign dptr_o      = dptr_q;
  assign bptr_o      = bptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      dptr_q <= '0;
      bptr_q <= '0;
      cnt_q  <= '0;
      ie_q   <= 1'b0;
    end else if (stop_i) begin
      st_q <= ST_IDLE;
    end else if (start_i) begin
      st_q   <= ST_W0;
      dptr_q <= dptr_i;
    end else if (beat) begin
      unique case (st_q)
        ST_W0: begin bptr_q <= mem_rdata_i; st_q <= ST_W1; end
        ST_W1: begin
          cnt_q <= mem_rdata_i[CNT_W-1:0] & ~CNT_W'(1);
          ie_q  <= mem_rdata_i[IE_BIT];
          st_q  <= ST_W2;
        end
        ST_W2: begin
          dptr_q <= mem_rdata_i;
          st_q   <= (cnt_q == '0) ? ST_W0 : ST_XFER;
        end
        ST_XFER: begin
          bptr_q <= bptr_q + 32'd2;
          cnt_q  <= cnt_q - CNT_W'(2);
          if (cnt_q == CNT_W'(2)) st_q <= ST_W0;
        end
        default: ;
      endcase
    end
  end

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !mem_req_o); // R9
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_hw_o && dptr_i[1:0] == 2'b00 && !$isunknown(mem_addr_o))
      |-> mem_addr_o[1:0] == 2'b00); // R2
  AST_XFER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_XFER) |-> cnt_q != '0); // R5

endmodule

// File: rtl/adma_regs.sv
module adma_regs
  import adma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        start_o,
  output logic        stop_o,
  output logic [7:0]  hwm_o,
  output logic [7:0]  beg_o,
  output logic [7:0]  end_o,
  output logic        rcv_o,
  output logic        run_o,
  output logic [31:0] dptr_o,
  input  logic [31:0] cur_dptr_i,
  input  logic [31:0] bptr_i,
  input  logic        desc_irq_i,
  output logic        irq_o
);

  logic ctrl_wr, ctrl_rd, load_q, irq_q;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == 2'd0);
  assign ctrl_rd = reg_rd_i && (reg_addr_i == 2'd0);
  assign start_o = ctrl_wr && reg_wdata_i[ACT_BIT];
  assign stop_o  = ctrl_wr && !reg_wdata_i[ACT_BIT];
  assign irq_o   = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hwm_o  <= '0;
      beg_o  <= '0;
      end_o  <= '0;
      rcv_o  <= 1'b0;
      load_q <= 1'b0;
      run_o  <= 1'b0;
      dptr_o <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        end_o  <= reg_wdata_i[31:24];
        beg_o  <= reg_wdata_i[23:16];
        hwm_o  <= reg_wdata_i[15:8];
        rcv_o  <= reg_wdata_i[RCV_BIT];
        load_q <= reg_wdata_i[LOAD_BIT];
        run_o  <= reg_wdata_i[ACT_BIT];
      end
      if (reg_wr_i && reg_addr_i == 2'd1) dptr_o <= reg_wdata_i;
      if (desc_irq_i)   irq_q <= 1'b1;
      else if (ctrl_rd) irq_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_i)
      2'd0:    reg_rdata_o = {end_o, beg_o, hwm_o, 4'b0000, rcv_o, load_q, run_o, irq_q};
      2'd1:    reg_rdata_o = run_o ? cur_dptr_i : dptr_o;
      2'd2:    reg_rdata_o = bptr_i;
      default: reg_rdata_o = '0;
    endcase
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_irq_i && ctrl_rd) |=> irq_o); // R8
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rd && !desc_irq_i) |=> !irq_o); // R8

endmodule

// File: rtl/adma_chan.sv
module adma_chan
  import adma_pkg::*;
#(
  parameter int FIFO_DW = 8,
  parameter int CNT_W   = 14,
  localparam int LW = $clog2(FIFO_DW * 4 + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_hw,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_gnt,
  input  logic [31:0] mem_rdata,
  output logic        dev_req,
  input  logic        dev_push,
  input  logic [15:0] dev_wdata,
  input  logic        dev_pop,
  output logic [15:0] dev_rdata
);

  logic        start, stop, rcv, run;
  logic [7:0]  hwm, beg, fin;
  logic [31:0] dptr_w, cur_dptr, bptr;
  logic        desc_done, desc_irq;
  logic        w_push, w_pop, f_push, f_pop, f_full, f_empty;
  logic [15:0] w_pdata, f_pdata, f_head;
  logic [LW-1:0] f_level, f_cap;

  adma_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .start_o(start), .stop_o(stop),
    .hwm_o(hwm), .beg_o(beg), .end_o(fin), .rcv_o(rcv), .run_o(run),
    .dptr_o(dptr_w), .cur_dptr_i(cur_dptr), .bptr_i(bptr),
    .desc_irq_i(desc_irq), .irq_o(irq)
  );

  adma_walk #(.CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .stop_i(stop), .dptr_i(dptr_w), .rcv_i(rcv),
    .fifo_full_i(f_full), .fifo_empty_i(f_empty), .fifo_head_i(f_head),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_hw_o(mem_hw),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
    .push_o(w_push), .pop_o(w_pop), .pdata_o(w_pdata),
    .desc_done_o(desc_done), .desc_irq_o(desc_irq),
    .dptr_o(cur_dptr), .bptr_o(bptr)
  );

  // direction picks which side fills and which side drains the slice
  assign f_push  = rcv ? dev_push  : w_push;
  assign f_pop   = rcv ? w_pop     : dev_pop;
  assign f_pdata = rcv ? dev_wdata : w_pdata;

  adma_fifo #(.DW(FIFO_DW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush_i(start),
    .beg_i(beg), .end_i(fin),
    .push_i(f_push), .pdata_i(f_pdata), .pop_i(f_pop),
    .head_o(f_head), .level_o(f_level), .cap_o(f_cap),
    .full_o(f_full), .empty_o(f_empty)
  );

  assign dev_rdata = f_head;

  always_comb begin
    if (!run)     dev_req = 1'b0;
    else if (rcv) dev_req = (int'(f_cap) - int'(f_level)) >= mark_eff(int'(hwm));
    else          dev_req = int'(f_level) >= mark_eff(int'(hwm));
  end

  AST_TX_REQ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req && !rcv) |-> !f_empty); // R11
  AST_DONE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    desc_done |-> run); // R6

endmodule

// File: tb/sim_adma_chan.sv
module sim_adma_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, mem_req, mem_we, mem_hw, mem_gnt, dev_req;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        dev_push = 1'b0, dev_pop = 1'b0;
  logic [15:0] dev_wdata = '0;
  logic [15:0] dev_rdata;

  logic        gnt_en = 1'b1;
  logic        mon_clr = 1'b0;
  logic        pk_en = 1'b0, pk_hw = 1'b0;
  logic [7:0]  pk_a = '0;
  logic [31:0] pk_d = '0;
  logic [31:0] mem [64];
  int          n_rd, n_wr, n_log;
  logic [31:0] log_addr [16];
  logic        log_hw [16];
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  adma_chan u0 (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_hw(mem_hw),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dev_req(dev_req), .dev_push(dev_push), .dev_wdata(dev_wdata),
    .dev_pop(dev_pop), .dev_rdata(dev_rdata)
  );

  // memory model: grant in the request cycle, halfwords in bits 15:0
  assign mem_gnt = mem_req && gnt_en;
  always_comb begin
    if (!mem_hw)         mem_rdata = mem[mem_addr[7:2]];
    else if (mem_addr[1]) mem_rdata = {16'h0, mem[mem_addr[7:2]][31:16]};
    else                 mem_rdata = {16'h0, mem[mem_addr[7:2]][15:0]};
  end

  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_we) begin
      if (mem_addr[1]) mem[mem_addr[7:2]][31:16] <= mem_wdata[15:0];
      else             mem[mem_addr[7:2]][15:0]  <= mem_wdata[15:0];
    end else if (pk_en) begin
      if (!pk_hw)       mem[pk_a[7:2]] <= pk_d;
      else if (pk_a[1]) mem[pk_a[7:2]][31:16] <= pk_d[15:0];
      else              mem[pk_a[7:2]][15:0]  <= pk_d[15:0];
    end
    if (mon_clr) begin
      n_rd <= 0; n_wr <= 0; n_log <= 0;
    end else if (mem_req && mem_gnt) begin
      if (mem_hw && !mem_we) n_rd <= n_rd + 1;
      if (mem_hw && mem_we)  n_wr <= n_wr + 1;
      if (n_log < 16) begin
        log_addr[n_log] <= mem_addr;
        log_hw[n_log]   <= mem_hw;
        n_log <= n_log + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d, input logic hw);
    @(negedge clk);
    pk_en = 1'b1; pk_a = a; pk_d = d; pk_hw = hw;
    @(negedge clk);
    pk_en = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic clr_mon();
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
  endtask

  task automatic pop_one(input string req, input logic [15:0] exp);
    @(negedge clk);
    chk(req, {16'h0, dev_rdata}, {16'h0, exp});
    dev_pop = 1'b1;
    @(negedge clk);
    dev_pop = 1'b0;
    cyc(3);
  endtask

  task automatic push_one(input logic [15:0] v);
    @(negedge clk);
    dev_push = 1'b1; dev_wdata = v;
    @(negedge clk);
    dev_push = 1'b0;
  endtask

  // control word: end[31:24] begin[23:16] mark[15:8] rcv[3] load[2] active[1]
  function automatic logic [31:0] cw(input int hwm, input int beg, input int fin,
                                     input bit rcv, input bit act);
    return {8'(fin), 8'(beg), 8'(hwm), 4'b0000, rcv, 1'b1, act, 1'b0};
  endfunction

  function automatic logic [15:0] hw_at(input logic [7:0] a);
    return a[1] ? mem[a[7:2]][31:16] : mem[a[7:2]][15:0];
  endfunction

  // {halfwords, begin, end, mark}
  localparam logic [31:0] VEC [4] = '{
    32'h04_00_01_02, 32'h08_01_02_04, 32'h06_00_08_08, 32'h02_02_04_00
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    mon_clr = 1'b1;
    cyc(5);
    rst_n = 1'b1;
    mon_clr = 1'b0;
    cyc(1);

    // R1 reset state
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 mem_req", {31'h0, mem_req}, 32'h0);
    chk("R1 dev_req", {31'h0, dev_req}, 32'h0);
    rreg(2'd0, rd); chk("R1 ctrl", rd, 32'h0);
    rreg(2'd2, rd); chk("R1 bptr", rd, 32'h0);

    // table of transmit cases
    for (int i = 0; i < 4; i++) begin
      int n, b, f, h, cap, lvl;
      logic [31:0] ebptr;
      n = int'(VEC[i][31:24]); b = int'(VEC[i][23:16]);
      f = int'(VEC[i][15:8]);  h = int'(VEC[i][7:0]);
      cap = (f - b) * 4;
      lvl = (n < cap) ? n : cap;
      ebptr = (n > cap) ? 32'h40 + 32'(2 * cap) : 32'hF0;
      poke(8'h00, 32'h40, 1'b0);
      poke(8'h04, 32'h8000_0000 | 32'(2 * n), 1'b0);
      poke(8'h08, 32'h10, 1'b0);
      poke(8'h10, 32'hF0, 1'b0);
      poke(8'h14, 32'h0, 1'b0);
      poke(8'h18, 32'h10, 1'b0);
      for (int k = 0; k < n; k++) poke(8'(8'h40 + 2 * k), 32'(i * 256 + k * 3 + 1), 1'b1);
      wreg(2'd1, 32'h0);
      clr_mon();
      wreg(2'd0, cw(h, b, f, 1'b0, 1'b1));
      cyc(40);
      if (i == 0) begin
        chk("R2 fetch0", log_addr[0], 32'h0);
        chk("R2 fetch1", log_addr[1], 32'h4);
        chk("R2 fetch2", log_addr[2], 32'h8);
        chk("R2 word", {31'h0, log_hw[2]}, 32'h0);
        chk("R3 first data", {log_addr[3][31:1], log_hw[3]}, {31'h20, 1'b1});
      end
      chk("R10 reads at fill", 32'(n_rd), 32'(lvl));
      chk("R11 dev_req", {31'h0, dev_req}, {31'h0, lvl >= ((h == 0) ? 1 : h)});
      rreg(2'd2, rd); chk("R12 bptr", rd, ebptr);
      for (int k = 0; k < n; k++) pop_one("R3 data", 16'(i * 256 + k * 3 + 1));
      chk("R5 total reads", 32'(n_rd), 32'(n));
      chk("R7 irq", {31'h0, irq}, 32'h1);
      rreg(2'd0, rd); chk("R8 status read", {31'h0, rd[0]}, 32'h1);
      cyc(1);
      chk("R8 cleared", {31'h0, irq}, 32'h0);
      wreg(2'd0, 32'h4);
    end

    // R7 descriptor without interrupt request
    poke(8'h04, 32'h4, 1'b0);
    poke(8'h40, 32'h1111, 1'b1);
    poke(8'h42, 32'h2222, 1'b1);
    clr_mon();
    wreg(2'd0, cw(1, 0, 1, 1'b0, 1'b1));
    cyc(30);
    chk("R5 no-ie reads", 32'(n_rd), 32'd2);
    chk("R7 no-ie irq", {31'h0, irq}, 32'h0);
    rreg(2'd0, rd); chk("R7 no-ie status", {31'h0, rd[0]}, 32'h0);
    wreg(2'd0, 32'h4);

    // R6 ring of two descriptors, then R9 stop
    poke(8'h00, 32'h40, 1'b0);
    poke(8'h04, 32'h8000_0004, 1'b0);
    poke(8'h08, 32'h10, 1'b0);
    poke(8'h10, 32'h60, 1'b0);
    poke(8'h14, 32'h4, 1'b0);
    poke(8'h18, 32'h0, 1'b0);
    poke(8'h40, 32'hA000, 1'b1); poke(8'h42, 32'hA001, 1'b1);
    poke(8'h60, 32'hB000, 1'b1); poke(8'h62, 32'hB001, 1'b1);
    clr_mon();
    wreg(2'd0, cw(1, 0, 8, 1'b0, 1'b1));
    cyc(100);
    chk("R10 ring fill", 32'(n_rd), 32'd32);
    for (int k = 0; k < 8; k++)
      pop_one("R6 ring order", {(k % 4 < 2) ? 4'hA : 4'hB, 11'h0, 1'(k % 2)});
    wreg(2'd0, 32'h4);
    @(negedge clk);
    chk("R9 req low", {31'h0, mem_req}, 32'h0);
    begin
      int snap;
      snap = n_rd;
      pop_one("R9 leftover", 16'hA000);
      cyc(20);
      chk("R9 no access", 32'(n_rd), 32'(snap));
    end
    rreg(2'd0, rd); chk("R9 active bit", {31'h0, rd[1]}, 32'h0);

    // R4 receive, R11 mark in receive
    poke(8'h80, 32'hC0, 1'b0);
    poke(8'h84, 32'h8000_0006, 1'b0);
    poke(8'h88, 32'h90, 1'b0);
    poke(8'h90, 32'hF0, 1'b0);
    poke(8'h94, 32'h0, 1'b0);
    poke(8'h98, 32'h90, 1'b0);
    wreg(2'd1, 32'h80);
    clr_mon();
    wreg(2'd0, cw(4, 0, 1, 1'b1, 1'b1));
    cyc(10);
    chk("R11 rx req empty", {31'h0, dev_req}, 32'h1);
    gnt_en = 1'b0;
    push_one(16'h5A01);
    #1 chk("R11 rx req free<mark", {31'h0, dev_req}, 32'h0);
    gnt_en = 1'b1;
    cyc(4);
    push_one(16'h5A02); cyc(3);
    push_one(16'h5A03); cyc(10);
    chk("R4 writes", 32'(n_wr), 32'd3);
    chk("R4 hw0", {16'h0, hw_at(8'hC0)}, 32'h5A01);
    chk("R4 hw1", {16'h0, hw_at(8'hC2)}, 32'h5A02);
    chk("R4 hw2", {16'h0, hw_at(8'hC4)}, 32'h5A03);
    chk("R7 rx irq", {31'h0, irq}, 32'h1);
    wreg(2'd0, 32'h4);
    rreg(2'd0, rd);

    // R8 completion and clearing read in one cycle
    poke(8'h20, 32'h40, 1'b0);
    poke(8'h24, 32'h8000_0000, 1'b0);
    poke(8'h28, 32'h20, 1'b0);
    wreg(2'd1, 32'h20);
    gnt_en = 1'b0;
    wreg(2'd0, cw(1, 0, 1, 1'b0, 1'b1));
    @(negedge clk); gnt_en = 1'b1;
    cyc(2); gnt_en = 1'b0;
    chk("R5 wait on third word", mem_addr, 32'h28);
    gnt_en = 1'b1; reg_rd = 1'b1; reg_addr = 2'd0;
    #1 chk("R8 read before set", {31'h0, reg_rdata[0]}, 32'h0);
    @(negedge clk);
    gnt_en = 1'b0; reg_rd = 1'b0;
    #1 chk("R8 set wins", {31'h0, irq}, 32'h1);
    rreg(2'd0, rd); chk("R8 later read", {31'h0, rd[0]}, 32'h1);
    #1 chk("R8 cleared after", {31'h0, irq}, 32'h0);
    wreg(2'd0, 32'h4);
    gnt_en = 1'b1;
    cyc(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule